// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block receives the control channel of a shared-memory coordination server as a stream of bytes. Every eight bytes form one message, assembled least significant byte first and read as a signed 64-bit value. A sideband flag, taken with the last byte of a message, tells whether the server attached a handle to it. The block checks the opening handshake in a fixed order: a protocol version word, then the local device's own ID, then any number of membership messages, until the value -1 announces the shared memory and completes setup.

Membership messages name a peer. A message with a handle is a connect. The block never receives vector numbers explicitly: it counts connects per peer, so the Nth connect for a peer stands for vector N-1. A message without a handle is a disconnect and clears that peer's count. The block reports each connect and disconnect as a one-cycle event carrying the peer and vector numbers. It pulses a separate strobe when a connect names the local device, so interrupt delivery can be armed. Any rejected message produces an error pulse. An error before setup completes leaves the block failed and inert until reset.

Top module: `peer_msg_seq`

## Requirements
- R1: A message is taken from eight accepted bytes (in_valid and in_ready high at a clock edge), the first byte being bits 7:0. in_handle is sampled with the eighth byte. in_ready is low for the one cycle in which the completed message is evaluated, and the resulting pulses are registered at the end of that cycle. After reset in_ready is high, setup_done is low and no pulse is active.
- R2: The first message must equal the parameter VERSION and carry no handle. Otherwise err_pulse fires and the block fails. A failed block gives no further pulses and never sets setup_done.
- R3: The second message is the own ID. It must carry no handle and lie in 0..65535, and is then shown on own_id. Otherwise err_pulse fires and the block fails.
- R4: After the ID, membership messages are processed until the value -1 arrives. That value raises setup_done, which stays high until reset, and it produces no event pulse.
- R5: A message value below -1 or above 65535 gives err_pulse and no event. During setup it also fails the block.
- R6: A value of -1 received after setup_done is already high gives err_pulse, and setup_done stays high.
- R7: A peer message with a handle is a connect. conn_pulse fires with evt_peer set to the peer and evt_vec set to the number of earlier connects counted for that peer, and the count then increments.
- R8: A connect for a peer whose count already equals NUM_VEC gives err_pulse, no event, and leaves the count unchanged.
- R9: A peer message without a handle is a disconnect. disc_pulse fires with evt_peer, and the peer's count returns to zero. A disconnect naming own_id gives err_pulse instead.
- R10: A peer ID at or above the table size PEERS gives err_pulse and no event.
- R11: A connect whose peer equals own_id also pulses local_vec_pulse in the same cycle as conn_pulse.
- R12: After setup, a rejected message does not stop the block; later messages are processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Message byte |
| in_handle | input | 1 | Handle attached; sampled with the eighth byte |
| in_ready | output | 1 | Block can take a byte |
| own_id | output | 16 | Local device ID from the handshake |
| setup_done | output | 1 | Shared memory announced, setup complete |
| conn_pulse | output | 1 | Connect event |
| disc_pulse | output | 1 | Disconnect event |
| evt_peer | output | 16 | Peer of the event |
| evt_vec | output | $clog2(NUM_VEC+1) | Vector implied by a connect |
| local_vec_pulse | output | 1 | Connect names the local device |
| err_pulse | output | 1 | Message rejected |

## Verification
Let the eighth byte be accepted at edge E. The bench expects in_ready low between E and E+1, and expects every pulse and every change of own_id or setup_done to appear after edge E+1 for exactly one cycle. Each message task therefore drops in_valid at the falling edge after E and checks in_ready there. It then waits for one more rising edge and compares all outputs at the following falling edge, which is also where the next message begins. Because the pulses last one cycle, any result that arrives a cycle early or late is seen as a miscompare.

// File: rtl/peer_msg_seq.sv
module peer_msg_seq #(
  parameter logic [63:0] VERSION = 64'd0,
  parameter int NUM_VEC = 4,
  parameter int PEERS   = 32,
  localparam int CW = $clog2(NUM_VEC + 1),
  localparam int PW = (PEERS > 1) ? $clog2(PEERS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_handle,
  output logic          in_ready,
  output logic [15:0]   own_id,
  output logic          setup_done,
  output logic          conn_pulse,
  output logic          disc_pulse,
  output logic [15:0]   evt_peer,
  output logic [CW-1:0] evt_vec,
  output logic          local_vec_pulse,
  output logic          err_pulse
);

  typedef enum logic [2:0] {S_VER, S_ID, S_MEM, S_RUN, S_FAIL} st_t;

  localparam logic [CW-1:0] VMAX = CW'(NUM_VEC);

  st_t         st;
  logic [63:0] sh;
  logic [2:0]  bcnt;
  logic        eval_q, hnd_q;
  logic [CW-1:0] cnt [PEERS];

  wire acc  = in_valid && in_ready;
  assign in_ready = !eval_q;

  wire signed [63:0] v = sh;
  wire        is_m1   = &sh;
  wire        bad_val = (v < -64'sd1) || (v > 64'sd65535);
  wire [15:0] p       = sh[15:0];
  wire        in_tab  = {16'd0, p} < 32'(PEERS);
  wire [PW-1:0] pidx  = p[PW-1:0];
  wire [CW-1:0] cur   = in_tab ? cnt[pidx] : '0;
  wire        setup_ph = (st == S_MEM);

  logic d_err, d_conn, d_disc, d_run;
  always_comb begin
    d_err = 1'b0; d_conn = 1'b0; d_disc = 1'b0; d_run = 1'b0;
    if (bad_val)             d_err = 1'b1;
    else if (is_m1) begin
      if (st == S_RUN)       d_err = 1'b1;
      else                   d_run = 1'b1;
    end
    else if (!in_tab)        d_err = 1'b1;
    else if (hnd_q) begin
      if (cur == VMAX)       d_err = 1'b1;
      else                   d_conn = 1'b1;
    end
    else if (p == own_id)    d_err = 1'b1;
    else                     d_disc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_VER; sh <= '0; bcnt <= '0; eval_q <= 1'b0; hnd_q <= 1'b0;
      own_id <= '0; setup_done <= 1'b0;
      conn_pulse <= 1'b0; disc_pulse <= 1'b0; local_vec_pulse <= 1'b0; err_pulse <= 1'b0;
      evt_peer <= '0; evt_vec <= '0;
      for (int i = 0; i < PEERS; i++) cnt[i] <= '0;
    end else begin
      conn_pulse <= 1'b0; disc_pulse <= 1'b0; local_vec_pulse <= 1'b0; err_pulse <= 1'b0;
      eval_q <= 1'b0;
      if (acc) begin
        sh   <= {in_data, sh[63:8]};
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          eval_q <= 1'b1;
          hnd_q  <= in_handle;
        end
      end
      if (eval_q) begin
        case (st)
          S_VER: begin
            if (sh == VERSION && !hnd_q) st <= S_ID;
            else begin err_pulse <= 1'b1; st <= S_FAIL; end
          end
          S_ID: begin
            if (!hnd_q && !sh[63] && sh <= 64'd65535) begin
              own_id <= p; st <= S_MEM;
            end else begin err_pulse <= 1'b1; st <= S_FAIL; end
          end
          S_MEM, S_RUN: begin
            if (d_err) begin
              err_pulse <= 1'b1;
              if (setup_ph) st <= S_FAIL;
            end
            if (d_run) begin st <= S_RUN; setup_done <= 1'b1; end
            if (d_conn) begin
              conn_pulse <= 1'b1; evt_peer <= p; evt_vec <= cur;
              cnt[pidx] <= cur + 1'b1;
              local_vec_pulse <= (p == own_id);
            end
            if (d_disc) begin
              disc_pulse <= 1'b1; evt_peer <= p; cnt[pidx] <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ready_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bcnt == 3'd7) |=> !in_ready);

  assert_fail_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAIL) |=> !(conn_pulse || disc_pulse || err_pulse || setup_done));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conn_pulse, disc_pulse, err_pulse}));

  assert_vec_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conn_pulse |-> (evt_vec < VMAX));

  assert_local_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    local_vec_pulse |-> (conn_pulse && evt_peer == own_id));

endmodule

// File: tb/peer_msg_seq_tb.sv
module peer_msg_seq_tb_top;
  localparam int CW = $clog2(4 + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_handle = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, setup_done, conn_pulse, disc_pulse, local_vec_pulse, err_pulse;
  logic [15:0] own_id, evt_peer;
  logic [CW-1:0] evt_vec;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  peer_msg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_handle(in_handle), .in_ready(in_ready), .own_id(own_id),
    .setup_done(setup_done), .conn_pulse(conn_pulse), .disc_pulse(disc_pulse),
    .evt_peer(evt_peer), .evt_vec(evt_vec), .local_vec_pulse(local_vec_pulse),
    .err_pulse(err_pulse)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(logic [63:0] val, logic h);
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_data = val[i*8 +: 8]; in_handle = h;
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    check("R1 ready low in evaluation cycle", {31'd0, in_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
  endtask

  // flags order: {conn, disc, err, local}
  task automatic msg(string tag, logic [63:0] val, logic h, logic [3:0] flags,
                     logic [15:0] peer, logic [CW-1:0] vec);
    send(val, h);
    check(tag, {28'd0, conn_pulse, disc_pulse, err_pulse, local_vec_pulse}, {28'd0, flags});
    if (flags[3] || flags[2]) check({tag, " peer"}, {16'd0, evt_peer}, {16'd0, peer});
    if (flags[3]) check({tag, " vector"}, {29'd0, evt_vec}, {29'd0, vec});
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset ready", {31'd0, in_ready}, 32'd1);
    check("R1 reset outputs", {26'd0, setup_done, conn_pulse, disc_pulse, err_pulse, local_vec_pulse, 1'b0}, 32'd0);
  endtask

  task automatic t_bad_version();
    do_reset();
    msg("R2 wrong version", 64'd1, 1'b0, 4'b0010, 0, 0);
    msg("R2 failed block ignores version", 64'd0, 1'b0, 4'b0000, 0, 0);
    msg("R2 failed block ignores memory", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0000, 0, 0);
    check("R2 setup_done stays low", {31'd0, setup_done}, 32'd0);
    do_reset();
    msg("R2 version with handle", 64'd0, 1'b1, 4'b0010, 0, 0);
  endtask

  task automatic t_bad_id();
    do_reset();
    msg("R3 version ok", 64'd0, 1'b0, 4'b0000, 0, 0);
    msg("R3 id with handle", 64'd2, 1'b1, 4'b0010, 0, 0);
    do_reset();
    msg("R3 version ok", 64'd0, 1'b0, 4'b0000, 0, 0);
    msg("R3 id out of range", 64'd70000, 1'b0, 4'b0010, 0, 0);
    msg("R3 failed ignores id", 64'd4, 1'b0, 4'b0000, 0, 0);
  endtask

  task automatic t_setup();
    do_reset();
    msg("R4 version", 64'd0, 1'b0, 4'b0000, 0, 0);
    msg("R3 own id", 64'd3, 1'b0, 4'b0000, 0, 0);
    check("R3 own_id value", {16'd0, own_id}, 32'd3);
    msg("R7 connect during setup", 64'd5, 1'b1, 4'b1000, 16'd5, 0);
    check("R4 not done before memory", {31'd0, setup_done}, 32'd0);
    msg("R4 memory message", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0000, 0, 0);
    check("R4 setup_done set", {31'd0, setup_done}, 32'd1);
  endtask

  task automatic t_connect();
    msg("R7 second connect", 64'd5, 1'b1, 4'b1000, 16'd5, 1);
    msg("R7 third connect", 64'd5, 1'b1, 4'b1000, 16'd5, 2);
    msg("R7 fourth connect", 64'd5, 1'b1, 4'b1000, 16'd5, 3);
    msg("R8 connect beyond vectors", 64'd5, 1'b1, 4'b0010, 0, 0);
    msg("R11 own connect", 64'd3, 1'b1, 4'b1001, 16'd3, 0);
    msg("R7 other peer independent", 64'd7, 1'b1, 4'b1000, 16'd7, 0);
  endtask

  task automatic t_disconnect();
    msg("R9 disconnect", 64'd5, 1'b0, 4'b0100, 16'd5, 0);
    msg("R9 count cleared", 64'd5, 1'b1, 4'b1000, 16'd5, 0);
    msg("R9 own disconnect rejected", 64'd3, 1'b0, 4'b0010, 0, 0);
    msg("R11 own count kept", 64'd3, 1'b1, 4'b1001, 16'd3, 1);
  endtask

  task automatic t_invalid();
    msg("R5 value below -1", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b0010, 0, 0);
    msg("R5 value above 65535", 64'd65536, 1'b1, 4'b0010, 0, 0);
    msg("R10 peer beyond table", 64'd40, 1'b1, 4'b0010, 0, 0);
    msg("R6 second memory message", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0010, 0, 0);
    check("R6 setup_done kept", {31'd0, setup_done}, 32'd1);
    msg("R12 processing continues", 64'd6, 1'b1, 4'b1000, 16'd6, 0);
  endtask

  task automatic t_fail_in_setup();
    do_reset();
    msg("R5 version", 64'd0, 1'b0, 4'b0000, 0, 0);
    msg("R5 id", 64'd1, 1'b0, 4'b0000, 0, 0);
    msg("R5 invalid in setup", 64'd70000, 1'b1, 4'b0010, 0, 0);
    msg("R5 block failed", 64'd2, 1'b1, 4'b0000, 0, 0);
  endtask

  initial begin
    t_reset();
    t_bad_version();
    t_bad_id();
    t_setup();
    t_connect();
    t_disconnect();
    t_invalid();
    t_fail_in_setup();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule